// File: doc/BRIEF.md
# Low-Power Mode Entry Sequencer

The block puts a whole device into a sleep state and takes it out again, driven by one active-high request pin. Its clock keeps running in sleep, so it can time its own transitions. When the request goes high, the block waits a short entry delay and then gates the device. While gated, every user output enable is forced off, so the pads go to high impedance. The data seen by the core is forced to zero instead of pad data, and the core-enable output is held low. When the request goes low, the block waits a much longer wake delay before it releases the gating.

Both delays are set in nanoseconds. Each is divided by the clock period and rounded up to a whole number of cycles. The request passes through a two-flop synchronizer first, and all delays are counted from the synchronized level. If the request reverses while a delay is still running, the pending transition is dropped and the opposite path is taken. The gating outputs never change during such an abort. A 2-bit status output shows the current phase.

Top module: `lp_seq_top`

## Requirements
- R1: The request is synchronized through two flops. After `lp_req_i` is first sampled high on a rising edge, `state_o` shows entering on the third rising edge, counting that first edge.
- R2: The entry delay is ENTER_CYC = ceil(ENTER_NS / CLK_PERIOD_NS) cycles. `state_o` becomes asleep exactly ENTER_CYC rising edges after it became entering, provided the synchronized request stays high.
- R3: The wake delay is EXIT_CYC = ceil(EXIT_NS / CLK_PERIOD_NS) cycles. `state_o` becomes awake exactly EXIT_CYC rising edges after it became waking, provided the synchronized request stays low.
- R4: While the gate is active, every bit of `pad_oe_o` and `pad_out_o` is 0. While it is inactive, they equal `core_oe_i` and `core_out_i`.
- R5: While the gate is active, `core_in_o` is all zeros whatever `pad_in_i` carries. While it is inactive, it equals `pad_in_i`.
- R6: `core_en_o` is 0 while the gate is active and 1 otherwise.
- R7: `state_o` encodes 0 = awake, 1 = entering, 2 = asleep, 3 = waking. The gate turns on when asleep is reached and turns off only when awake is reached.
- R8: If the synchronized request falls while entering from awake, the next state is awake. The gate never turns on in that case.
- R9: If the synchronized request rises while waking, the next state is entering and the full entry delay restarts, with the gate held on. If it then falls while entering, the next state is waking and the full wake delay restarts.
- R10: An asserted `rst_ni` puts the block in awake with the gate off, so `core_en_o` = 1 and all pads pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lp_req_i | input | 1 | Sleep request, high selects low power |
| core_oe_i | input | NUM_IO | Output enables from the core |
| core_out_i | input | NUM_IO | Output data from the core |
| pad_in_i | input | NUM_IO | Input data from the pads |
| pad_oe_o | output | NUM_IO | Gated output enables to the pads |
| pad_out_o | output | NUM_IO | Gated output data to the pads |
| core_in_o | output | NUM_IO | Gated input data to the core |
| core_en_o | output | 1 | Core enable, low in sleep |
| state_o | output | 2 | Phase: awake, entering, asleep, waking |

## Verification
The bench uses a 5 ns clock period, ENTER_NS = 42 and EXIT_NS = 103, which gives 9 and 21 cycle delays. Neither value divides evenly by the period, so ceiling rounding is exercised. The short delays let the bench run full entries, full wakes and aborts in both directions, including a one-cycle request pulse, within a few hundred cycles. The default 800 ns / 200 us values would need 40,000 cycles per wake. The bench compares every output against a behavioural model on every clock and also measures each transition's exact length from the status output.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE    = 2'd0,
    ST_ENTERING = 2'd1,
    ST_ASLEEP   = 2'd2,
    ST_WAKING   = 2'd3
  } lp_state_e;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/lp_timer.sv
module lp_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // one step per cycle, never skips
  assert_count_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_load_taken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/lp_gate.sv
module lp_gate #(
  parameter int unsigned NUM_IO = 8
) (
  input  logic              gate_i,
  input  logic [NUM_IO-1:0] core_oe_i,
  input  logic [NUM_IO-1:0] core_out_i,
  input  logic [NUM_IO-1:0] pad_in_i,
  output logic [NUM_IO-1:0] pad_oe_o,
  output logic [NUM_IO-1:0] pad_out_o,
  output logic [NUM_IO-1:0] core_in_o
);
  for (genvar i = 0; i < NUM_IO; i++) begin : g_io
    assign pad_oe_o[i]  = core_oe_i[i]  & ~gate_i;
    assign pad_out_o[i] = core_out_i[i] & ~gate_i;
    assign core_in_o[i] = pad_in_i[i]   & ~gate_i;
  end

  always_comb begin
    if (gate_i) begin
      assert_pads_off_R4: assert (pad_oe_o == '0 && pad_out_o == '0);
      assert_inputs_off_R5: assert (core_in_o == '0);
    end
  end
endmodule

// File: rtl/lp_seq_top.sv
module lp_seq_top
  import lp_pkg::*;
#(
  parameter int unsigned NUM_IO        = 8,
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned ENTER_NS      = 800,
  parameter int unsigned EXIT_NS       = 200000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lp_req_i,
  input  logic [NUM_IO-1:0] core_oe_i,
  input  logic [NUM_IO-1:0] core_out_i,
  input  logic [NUM_IO-1:0] pad_in_i,
  output logic [NUM_IO-1:0] pad_oe_o,
  output logic [NUM_IO-1:0] pad_out_o,
  output logic [NUM_IO-1:0] core_in_o,
  output logic              core_en_o,
  output logic [1:0]        state_o
);
  localparam int unsigned ENTER_CYC = ns_to_cyc(ENTER_NS, CLK_PERIOD_NS);
  localparam int unsigned EXIT_CYC  = ns_to_cyc(EXIT_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC   = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int unsigned CNT_W     = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] ENTER_LD = CNT_W'(ENTER_CYC - 1);
  localparam logic [CNT_W-1:0] EXIT_LD  = CNT_W'(EXIT_CYC - 1);

  lp_state_e        state_q, state_d;
  logic             req_s, gate_q, load, zero;
  logic [CNT_W-1:0] load_val;

  lp_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lp_req_i), .q_o(req_s)
  );

  lp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .load_val_i(load_val), .zero_o(zero)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = ENTER_LD;
    unique case (state_q)
      ST_AWAKE: if (req_s) begin
        state_d = ST_ENTERING; load = 1'b1; load_val = ENTER_LD;
      end
      ST_ENTERING: begin
        if (!req_s) begin
          // abort: a gated device must still honour the wake delay
          if (gate_q) begin
            state_d = ST_WAKING; load = 1'b1; load_val = EXIT_LD;
          end else begin
            state_d = ST_AWAKE;
          end
        end else if (zero) begin
          state_d = ST_ASLEEP;
        end
      end
      ST_ASLEEP: if (!req_s) begin
        state_d = ST_WAKING; load = 1'b1; load_val = EXIT_LD;
      end
      ST_WAKING: begin
        if (req_s) begin
          state_d = ST_ENTERING; load = 1'b1; load_val = ENTER_LD;
        end else if (zero) begin
          state_d = ST_AWAKE;
        end
      end
      default: state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_AWAKE;
      gate_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_ASLEEP)     gate_q <= 1'b1;
      else if (state_d == ST_AWAKE) gate_q <= 1'b0;
    end
  end

  lp_gate #(.NUM_IO(NUM_IO)) u_gate (
    .gate_i(gate_q), .core_oe_i(core_oe_i), .core_out_i(core_out_i),
    .pad_in_i(pad_in_i), .pad_oe_o(pad_oe_o), .pad_out_o(pad_out_o),
    .core_in_o(core_in_o)
  );

  assign core_en_o = ~gate_q;
  assign state_o   = state_q;

  assert_asleep_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ASLEEP) |-> (!core_en_o && pad_oe_o == '0 && core_in_o == '0));
  assert_awake_open_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AWAKE) |-> (core_en_o && pad_oe_o == core_oe_i));
  assert_enter_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ENTERING && req_s && zero) |=> (state_q == ST_ASLEEP));
  assert_wake_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKING && !req_s && zero) |=> (state_q == ST_AWAKE));
  assert_gate_edges_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(core_en_o) |-> (state_q == ST_ASLEEP || state_q == ST_AWAKE));
  assert_abort_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ENTERING && !req_s && core_en_o) |=> (state_q == ST_AWAKE && core_en_o));
endmodule

// File: tb/tb_lp_seq_top.sv
module tb_lp_seq_top;
  localparam int NIO = 8;
  localparam int PER = 5;
  localparam int ENS = 42;
  localparam int EXS = 103;
  localparam int ENC = (ENS + PER - 1) / PER; // 9
  localparam int EXC = (EXS + PER - 1) / PER; // 21

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [NIO-1:0] c_oe = '0, c_out = '0, p_in = '0;
  logic [NIO-1:0] p_oe, p_out, c_in;
  logic c_en;
  logic [1:0] st;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lp_seq_top #(.NUM_IO(NIO), .CLK_PERIOD_NS(PER), .ENTER_NS(ENS), .EXIT_NS(EXS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lp_req_i(req), .core_oe_i(c_oe), .core_out_i(c_out),
    .pad_in_i(p_in), .pad_oe_o(p_oe), .pad_out_o(p_out), .core_in_o(c_in),
    .core_en_o(c_en), .state_o(st)
  );

  // behavioural reference: request history queue, phase, elapsed cycles, gate flag
  bit req_hist[$];
  int m_st = 0, m_el = 0;
  bit m_gate = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_hist = {}; m_st = 0; m_el = 0; m_gate = 0;
    end else begin
      bit rs;
      rs = (req_hist.size() >= 2) ? req_hist[req_hist.size()-2] : 1'b0;
      req_hist.push_back(req);
      if (req_hist.size() > 4) void'(req_hist.pop_front());
      m_el++;
      if (m_st == 0 && rs) begin m_st = 1; m_el = 0; end
      else if (m_st == 1 && !rs) begin
        if (m_gate) begin m_st = 3; m_el = 0; end else m_st = 0;
      end
      else if (m_st == 1 && m_el == ENC) begin m_st = 2; m_gate = 1; end
      else if (m_st == 2 && !rs) begin m_st = 3; m_el = 0; end
      else if (m_st == 3 && rs) begin m_st = 1; m_el = 0; end
      else if (m_st == 3 && m_el == EXC) begin m_st = 0; m_gate = 0; end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  int prev_st = 0, t_ent = 0, t_wk = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      chk("R7 state", int'(st), m_st);
      chk("R4 pad_oe", int'(p_oe), m_gate ? 0 : int'(c_oe));
      chk("R4 pad_out", int'(p_out), m_gate ? 0 : int'(c_out));
      chk("R5 core_in", int'(c_in), m_gate ? 0 : int'(p_in));
      chk("R6 core_en", int'(c_en), m_gate ? 0 : 1);
      if (int'(st) != prev_st) begin
        if (st == 2'd1) t_ent = cyc;
        if (st == 2'd3) t_wk = cyc;
        if (st == 2'd2) chk("R2 entry length", cyc - t_ent, ENC);
        if (st == 2'd0 && prev_st == 3) chk("R3 wake length", cyc - t_wk, EXC);
      end
      prev_st = int'(st);
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      c_oe = NIO'($urandom); c_out = NIO'($urandom); p_in = NIO'($urandom);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    summary();
  end

  initial begin
    c_oe = 8'hA5; c_out = 8'h3C; p_in = 8'h5A;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset state", int'(st), 0);
    chk("R10 reset core_en", int'(c_en), 1);
    chk("R10 reset pad_oe", int'(p_oe), 8'hA5);
    rst_n = 1'b1;
    step(6);
    // R1: entering on third sampling edge
    @(negedge clk); req = 1'b1;
    @(negedge clk); chk("R1 edge1", int'(st), 0);
    @(negedge clk); chk("R1 edge2", int'(st), 0);
    @(negedge clk); chk("R1 edge3", int'(st), 1);
    step(ENC + 4);
    chk("R2 asleep", int'(st), 2);
    p_in = 8'hFF; @(negedge clk);
    chk("R5 pad_in ignored", int'(c_in), 0);
    step(5);
    req = 1'b0;
    step(EXC + 5);
    chk("R3 awake again", int'(st), 0);
    // R8: short pulse aborts entry
    req = 1'b1; step(5); req = 1'b0; step(4);
    chk("R8 abort to awake", int'(st), 0);
    chk("R8 never gated", int'(c_en), 1);
    // one-cycle pulse still starts entry
    req = 1'b1; step(1); req = 1'b0; step(6);
    chk("R8 one-cycle pulse", int'(st), 0);
    // R9: abort waking, then abort entering from gated
    req = 1'b1; step(ENC + 5);
    req = 1'b0; step(7);
    chk("R9 waking", int'(st), 3);
    req = 1'b1; step(4);
    chk("R9 entering gated", int'(st), 1);
    chk("R9 gate held", int'(c_en), 0);
    req = 1'b0; step(4);
    chk("R9 back to waking", int'(st), 3);
    req = 1'b1; step(ENC + 5);
    chk("R9 asleep", int'(st), 2);
    req = 1'b0; step(EXC + 6);
    chk("R3 final awake", int'(st), 0);
    step(10);
    done = 1;
    summary();
  end
endmodule